// File: doc/BRIEF.md
# Memory Bank Access Qualifier

This block holds the control settings of one memory bank and judges each bus access that an external address comparator flags as a hit on that bank. When a transfer starts, it decides from the bank settings whether the access goes ahead at all. If it does, the block picks who serves it: the general-purpose machine, the SDRAM machine, one of three user-programmable machines, or a slave outside the controller. It also picks which bus (primary or local) the bank is attached to. It then drives the bank chip select, the one-cycle machine start strobe and the data-valid strobe.

Writes to a write-protected bank are stopped. They raise a sticky error flag and, when the bus monitor is on, a transfer-error request. Data beats reported by the timing engine can be passed straight through or delayed by one clock. The address comparison, the timing engines and the bus-monitor timer live outside the block and appear only as strobes.

The controller has five states.
- IDLE waits for a start with a hit. From there it goes to LAUNCH (accepted by an internal machine), EXTERN (accepted by an external slave) or BLOCKED (write-protect violation), or it stays in IDLE when the bank does not answer.
- LAUNCH always goes to ACTIVE.
- ACTIVE returns to IDLE on the done strobe.
- EXTERN returns to IDLE on the done strobe.
- BLOCKED returns to IDLE after one cycle.

Top module: `mem_bank_qualifier`

## Requirements
- R1: Reset state.
  - For bank index 0, reset leaves the bank valid, machine select 000, and pipelining, external override and write protect cleared.
  - A bank with any other index resets invalid.
  - After reset every output is 0.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the bank settings. The field positions are: bit 0 valid, bit 1 pipelining, bit 2 external override, bit 3 write protect, bits 6:4 machine select. The new value governs starts in later cycles.
- R3: Normal access sequence.
  - In IDLE, `acc_start` with `acc_hit` on a valid, non-reserved, non-external bank that is not a protected write moves to LAUNCH.
  - In LAUNCH, `cs` is 1 and `mach_start` carries one one-hot pulse.
  - ACTIVE follows. `cs` stays 1 until the cycle in which `acc_done` is high, and IDLE follows that cycle.
  - A start without a hit does nothing.
- R4: Machine select maps to `mach_start` bits as follows: 000/001 bit 0 (general-purpose), 010/011 bit 1 (SDRAM), 100 bit 2, 101 bit 3, 110 bit 4. `bus_local` is 1 during the access for 001 and 011 and 0 for 000 and 010.
- R5: For machine select 100, 101 and 110, `bus_local` during the access equals `upm_bus_sel` as sampled at the start cycle.
- R6: With the valid bit 0, or machine select 111, a start produces no `cs`, no `mach_start` and no other output, and the block stays in IDLE.
- R7: A write start to a valid bank with write protect 1 goes to BLOCKED for one cycle. In that cycle `cs`, `dval` and `mach_start` stay 0 even if beats are reported. Reads to that bank proceed normally.
- R8: `tea_req` is 1 only in BLOCKED and only while `busmon_en` is 1.
- R9: Sticky write-protect error.
  - `wp_err` rises in the cycle after a write-protect violation and stays 1.
  - A cycle with `stat_we` high and `stat_wdata` 1 clears it from the next cycle.
  - `stat_wdata` 0 leaves it unchanged.
  - A violation in the same cycle as a clear leaves it set.
- R10: With the external override set, an accepted start goes to EXTERN.
  - In EXTERN, `ext_claim` is 1 until `acc_done`, while `cs`, `mach_start`, `dval` and `bus_local` stay 0, whatever the machine select.
  - Write protect still applies to such a bank.
- R11: Data-valid timing.
  - Without pipelining, `dval` equals `beat_in` in ACTIVE cycles.
  - With pipelining, each ACTIVE beat shows on `dval` exactly one cycle later, including the cycle after `acc_done`.
  - Beats outside ACTIVE never produce `dval`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load bank settings |
| cfg_wdata | input | 7 | Bank settings value (layout in R2) |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Write 1 to clear the write-protect error |
| acc_start | input | 1 | Transfer start |
| acc_hit | input | 1 | Address matched this bank |
| acc_write | input | 1 | 1 = write, 0 = read |
| upm_bus_sel | input | 1 | Bus choice for user-programmable machines (1 = local) |
| busmon_en | input | 1 | Bus monitor enabled |
| beat_in | input | 1 | Data beat from the timing engine |
| acc_done | input | 1 | Access finished |
| cs | output | 1 | Bank chip select |
| dval | output | 1 | Data valid |
| mach_start | output | 5 | One-hot machine start pulse |
| bus_local | output | 1 | Access runs on the local bus |
| ext_claim | output | 1 | Access handed to an external slave |
| tea_req | output | 1 | Transfer-error request |
| wp_err | output | 1 | Sticky write-protect error |

## Verification
The sticky error flag can be set by a violation and cleared by a status write in one and the same cycle. The bench provokes this by driving a protected write start together with a write-1 clear, after the flag is already set. It expects the flag to read 1 throughout BLOCKED and the cycle after, so the set side must win. A delayed data beat landing in the first IDLE cycle after `acc_done` also overlaps the end of the chip select. The bench expects `dval` high with `cs` already low in that cycle.

// File: rtl/mbq_pkg.sv
package mbq_pkg;
    localparam int MSEL_W     = 3;
    localparam int NUM_MACH   = 5;
    localparam int MACH_IDX_W = $clog2(NUM_MACH);

    typedef struct packed {
        logic [MSEL_W-1:0] msel;
        logic              wprot;
        logic              ext_en;
        logic              pipe;
        logic              valid;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);
    localparam logic [MSEL_W-1:0] MSEL_RSVD = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_ACTIVE,
        ST_EXTERN,
        ST_BLOCKED
    } acc_state_t;
endpackage

// File: rtl/mbq_cfg_regs.sv
module mbq_cfg_regs
    import mbq_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             err_set,
    input  logic             err_clr,
    output bank_cfg_t        cfg_o,
    output logic             wp_err_o
);
    localparam logic RST_VALID = (BANK_ID == 0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '{msel: '0, wprot: 1'b0, ext_en: 1'b0, pipe: 1'b0, valid: RST_VALID};
        end else if (cfg_we) begin
            cfg_o <= bank_cfg_t'(cfg_wdata);
        end
    end

    // set side has priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)       wp_err_o <= 1'b0;
        else if (err_set) wp_err_o <= 1'b1;
        else if (err_clr) wp_err_o <= 1'b0;
    end

    p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !err_set) |=> !wp_err_o);
    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_err_o && !err_clr) |=> wp_err_o);
endmodule

// File: rtl/mbq_route_dec.sv
module mbq_route_dec
    import mbq_pkg::*;
(
    input  logic [MSEL_W-1:0]   msel,
    input  logic                upm_bus_sel,
    output logic [NUM_MACH-1:0] mach_hot,
    output logic                bus_local,
    output logic                rsvd
);
    logic                  is_upm;
    logic [MACH_IDX_W-1:0] idx;

    always_comb begin
        is_upm    = msel[MSEL_W-1];
        rsvd      = (msel == MSEL_RSVD);
        idx       = is_upm ? MACH_IDX_W'(2 + msel[1:0]) : MACH_IDX_W'(msel[1]);
        bus_local = is_upm ? upm_bus_sel : msel[0];
    end

    for (genvar i = 0; i < NUM_MACH; i++) begin : g_hot
        assign mach_hot[i] = !rsvd && (idx == MACH_IDX_W'(i));
    end
endmodule

// File: rtl/mbq_beat_pipe.sv
module mbq_beat_pipe (
    input  logic clk,
    input  logic rst_n,
    input  logic pipe_en,
    input  logic beat_i,
    output logic dval_o
);
    logic beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) beat_q <= 1'b0;
        else        beat_q <= beat_i;
    end

    assign dval_o = pipe_en ? beat_q : beat_i;

    p_beat_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && beat_i) |=> dval_o);
endmodule

// File: rtl/mem_bank_qualifier.sv
module mem_bank_qualifier
    import mbq_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                stat_we,
    input  logic                stat_wdata,
    input  logic                acc_start,
    input  logic                acc_hit,
    input  logic                acc_write,
    input  logic                upm_bus_sel,
    input  logic                busmon_en,
    input  logic                beat_in,
    input  logic                acc_done,
    output logic                cs,
    output logic                dval,
    output logic [NUM_MACH-1:0] mach_start,
    output logic                bus_local,
    output logic                ext_claim,
    output logic                tea_req,
    output logic                wp_err
);
    acc_state_t          state, state_nx;
    bank_cfg_t           cfg;
    logic [NUM_MACH-1:0] dec_hot, lat_hot;
    logic                dec_bus, dec_rsvd, lat_bus, lat_pipe;
    logic                req, viol, take_int, take_ext, beat_live;

    mbq_cfg_regs #(.BANK_ID(BANK_ID)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .err_set(viol), .err_clr(stat_we && stat_wdata),
        .cfg_o(cfg), .wp_err_o(wp_err)
    );

    mbq_route_dec u_dec (
        .msel(cfg.msel), .upm_bus_sel(upm_bus_sel),
        .mach_hot(dec_hot), .bus_local(dec_bus), .rsvd(dec_rsvd)
    );

    always_comb begin
        req      = (state == ST_IDLE) && acc_start && acc_hit;
        viol     = req && cfg.valid && cfg.wprot && acc_write;
        take_ext = req && cfg.valid && !viol && cfg.ext_en;
        take_int = req && cfg.valid && !viol && !cfg.ext_en && !dec_rsvd;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (viol)          state_nx = ST_BLOCKED;
                else if (take_ext) state_nx = ST_EXTERN;
                else if (take_int) state_nx = ST_LAUNCH;
            end
            ST_LAUNCH:  state_nx = ST_ACTIVE;
            ST_ACTIVE:  if (acc_done) state_nx = ST_IDLE;
            ST_EXTERN:  if (acc_done) state_nx = ST_IDLE;
            ST_BLOCKED: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // routing captured at the decision cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_hot  <= '0;
            lat_bus  <= 1'b0;
            lat_pipe <= 1'b0;
        end else if (take_int) begin
            lat_hot  <= dec_hot;
            lat_bus  <= dec_bus;
            lat_pipe <= cfg.pipe;
        end
    end

    assign beat_live = beat_in && (state == ST_ACTIVE);

    mbq_beat_pipe u_pipe (
        .clk(clk), .rst_n(rst_n), .pipe_en(lat_pipe),
        .beat_i(beat_live), .dval_o(dval)
    );

    always_comb begin
        cs         = 1'b0;
        mach_start = '0;
        bus_local  = 1'b0;
        ext_claim  = 1'b0;
        tea_req    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LAUNCH: begin
                cs         = 1'b1;
                mach_start = lat_hot;
                bus_local  = lat_bus;
            end
            ST_ACTIVE: begin
                cs        = 1'b1;
                bus_local = lat_bus;
            end
            ST_EXTERN:  ext_claim = 1'b1;
            ST_BLOCKED: tea_req   = busmon_en;
            default: ;
        endcase
    end

    p_start_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mach_start));
    p_cs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> ($past(cfg.valid) && $past(cfg.msel) != MSEL_RSVD));
    p_blocked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLOCKED) |-> (!cs && !dval && mach_start == '0));
    p_viol_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> wp_err);
    p_ext_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_claim) |-> $past(cfg.ext_en));
endmodule

// File: tb/mem_bank_qualifier_bench.sv
`timescale 1ns/1ps
module mem_bank_qualifier_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, stat_we = 0, stat_wdata = 0;
    logic [6:0] cfg_wdata = '0;
    logic acc_start = 0, acc_hit = 0, acc_write = 0, upm_bus_sel = 0;
    logic busmon_en = 0, beat_in = 0, acc_done = 0;
    logic cs, dval, bus_local, ext_claim, tea_req, wp_err;
    logic [4:0] mach_start;
    logic cs_b, dval_b, bus_b, ext_b, tea_b, err_b;
    logic [4:0] mach_b;

    always #2 clk = ~clk;

    mem_bank_qualifier #(.BANK_ID(0)) u_mem_bank_qualifier (
        .clk, .rst_n, .cfg_we, .cfg_wdata, .stat_we, .stat_wdata,
        .acc_start, .acc_hit, .acc_write, .upm_bus_sel, .busmon_en,
        .beat_in, .acc_done, .cs, .dval, .mach_start, .bus_local,
        .ext_claim, .tea_req, .wp_err);

    mem_bank_qualifier #(.BANK_ID(1)) u_other_bank (
        .clk, .rst_n, .cfg_we, .cfg_wdata, .stat_we, .stat_wdata,
        .acc_start, .acc_hit, .acc_write, .upm_bus_sel, .busmon_en,
        .beat_in, .acc_done, .cs(cs_b), .dval(dval_b), .mach_start(mach_b),
        .bus_local(bus_b), .ext_claim(ext_b), .tea_req(tea_b), .wp_err(err_b));

    typedef struct { logic [10:0] exp; string req; } item_t;
    item_t q[$];
    int checks = 0, errors = 0;
    bit b_chk = 0, finished = 0;

    localparam logic [4:0] M0 = 5'b00000, GP = 5'b00001, SD = 5'b00010;
    localparam logic [4:0] UA = 5'b00100, UB = 5'b01000, UC = 5'b10000;

    function automatic logic [10:0] e(logic c, logic d, logic [4:0] m,
                                      logic b, logic x, logic t, logic w);
        return {c, d, m, b, x, t, w};
    endfunction

    function automatic logic [6:0] cfgw(logic v, logic p, logic x, logic w, logic [2:0] ms);
        return {ms, w, x, p, v};
    endfunction

    task automatic step(input logic st, hit, wr, bt, dn, upm, bm, swe, swd, cwe,
                        input logic [6:0] cwd, input logic [10:0] exp, input string req);
        @(posedge clk); #1;
        acc_start = st; acc_hit = hit; acc_write = wr; beat_in = bt; acc_done = dn;
        upm_bus_sel = upm; busmon_en = bm; stat_we = swe; stat_wdata = swd;
        cfg_we = cwe; cfg_wdata = cwd;
        q.push_back('{exp: exp, req: req});
    endtask

    task automatic idle(input logic [10:0] exp, input string req);
        step(0,0,0,0,0,0,0,0,0,0,'0, exp, req);
    endtask
    task automatic cfg(input logic [6:0] v, input logic [10:0] exp);
        step(0,0,0,0,0,0,0,0,0,1, v, exp, "R2");
    endtask
    task automatic go(input logic wr, input logic upm, input logic bm,
                      input logic [10:0] exp, input string req);
        step(1,1,wr,0,0,upm,bm,0,0,0,'0, exp, req);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [10:0] got;
            it  = q.pop_front();
            got = {cs, dval, mach_start, bus_local, ext_claim, tea_req, wp_err};
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s got %b expected %b", it.req, got, it.exp);
            end
        end
        if (b_chk) begin
            checks++;
            if (cs_b !== 1'b0) begin
                errors++;
                $display("FAIL R1 other bank cs got %b expected 0", cs_b);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(0, "R1");                       // still in reset
        @(posedge clk); #1 rst_n = 1'b1;
        idle(0, "R1");
        // general-purpose, primary bus, no pipelining (reset config)
        go(0,0,0, 0, "R3");
        idle(e(1,0,GP,0,0,0,0), "R3_R4");
        b_chk = 1;
        step(0,0,0,1,0,0,0,0,0,0,'0, e(1,1,M0,0,0,0,0), "R11");
        b_chk = 0;
        step(0,0,0,1,1,0,0,0,0,0,'0, e(1,1,M0,0,0,0,0), "R3");
        idle(0, "R3");
        step(0,0,0,1,0,0,0,0,0,0,'0, 0, "R11");      // beat in IDLE ignored
        step(1,0,0,0,0,0,0,0,0,0,'0, 0, "R3");       // start without hit
        idle(0, "R3");
        // SDRAM local bus, pipelined
        cfg(cfgw(1,1,0,0,3'b011), 0);
        go(0,0,0, 0, "R3");
        idle(e(1,0,SD,1,0,0,0), "R4");
        step(0,0,0,1,0,0,0,0,0,0,'0, e(1,0,M0,1,0,0,0), "R11");
        step(0,0,0,1,1,0,0,0,0,0,'0, e(1,1,M0,1,0,0,0), "R11");
        idle(e(0,1,M0,0,0,0,0), "R11");
        idle(0, "R11");
        // user machine B, bus from select input
        cfg(cfgw(1,0,0,0,3'b101), 0);
        go(0,1,0, 0, "R5");
        idle(e(1,0,UB,1,0,0,0), "R5");
        idle(e(1,0,M0,1,0,0,0), "R5");
        step(0,0,0,0,1,0,0,0,0,0,'0, e(1,0,M0,1,0,0,0), "R3");
        idle(0, "R3");
        // user machine C, primary
        cfg(cfgw(1,0,0,0,3'b110), 0);
        go(0,0,0, 0, "R5");
        idle(e(1,0,UC,0,0,0,0), "R5");
        step(0,0,0,0,1,1,0,0,0,0,'0, e(1,0,M0,0,0,0,0), "R5");
        idle(0, "R3");
        // general-purpose local
        cfg(cfgw(1,0,0,0,3'b001), 0);
        go(0,0,0, 0, "R4");
        idle(e(1,0,GP,1,0,0,0), "R4");
        step(0,0,0,0,1,0,0,0,0,0,'0, e(1,0,M0,1,0,0,0), "R4");
        idle(0, "R4");
        // user machine A
        cfg(cfgw(1,0,0,0,3'b100), 0);
        go(0,0,0, 0, "R4");
        idle(e(1,0,UA,0,0,0,0), "R4");
        step(0,0,0,0,1,0,0,0,0,0,'0, e(1,0,M0,0,0,0,0), "R4");
        idle(0, "R4");
        // invalid bank and reserved select
        cfg(cfgw(0,0,0,0,3'b000), 0);
        go(0,0,0, 0, "R6");
        idle(0, "R6");
        step(0,0,0,1,1,0,0,0,0,0,'0, 0, "R6");
        cfg(cfgw(1,0,0,0,3'b111), 0);
        go(0,0,0, 0, "R6");
        idle(0, "R6");
        idle(0, "R6");
        // write protect
        cfg(cfgw(1,0,0,1,3'b000), 0);
        go(0,0,0, 0, "R7");
        idle(e(1,0,GP,0,0,0,0), "R7");
        step(0,0,0,0,1,0,0,0,0,0,'0, e(1,0,M0,0,0,0,0), "R7");
        idle(0, "R7");
        go(1,0,1, 0, "R7");
        step(0,0,0,1,0,0,1,0,0,0,'0, e(0,0,M0,0,0,1,1), "R7_R8_R9");
        idle(e(0,0,M0,0,0,0,1), "R9");
        step(0,0,0,0,0,0,0,1,0,0,'0, e(0,0,M0,0,0,0,1), "R9");
        idle(e(0,0,M0,0,0,0,1), "R9");
        step(0,0,0,0,0,0,0,1,1,0,'0, e(0,0,M0,0,0,0,1), "R9");
        idle(0, "R9");
        go(1,0,0, 0, "R8");
        idle(e(0,0,M0,0,0,0,1), "R8");
        idle(e(0,0,M0,0,0,0,1), "R9");
        step(1,1,1,0,0,0,0,1,1,0,'0, e(0,0,M0,0,0,0,1), "R9");  // violation with clear
        idle(e(0,0,M0,0,0,0,1), "R9");
        idle(e(0,0,M0,0,0,0,1), "R9");
        step(0,0,0,0,0,0,0,1,1,0,'0, e(0,0,M0,0,0,0,1), "R9");
        idle(0, "R9");
        // external slave
        cfg(cfgw(1,0,1,0,3'b011), 0);
        go(1,0,0, 0, "R10");
        step(0,0,0,1,0,0,0,0,0,0,'0, e(0,0,M0,0,1,0,0), "R10");
        step(0,0,0,0,1,0,0,0,0,0,'0, e(0,0,M0,0,1,0,0), "R10");
        idle(0, "R10");
        cfg(cfgw(1,0,1,1,3'b011), 0);
        go(1,0,1, 0, "R10");
        step(0,0,0,0,0,0,1,0,0,0,'0, e(0,0,M0,0,0,1,1), "R10");
        idle(e(0,0,M0,0,0,0,1), "R10");
        step(0,0,0,0,0,0,0,1,1,0,'0, e(0,0,M0,0,0,0,1), "R9");
        idle(0, "R9");
        repeat (3) @(posedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule